// File: doc/BRIEF.md
# Programmable-Timing External Bus Master

This block runs single transfers on an external parallel memory bus for one chip-select, such as a NOR flash, an FPGA register window or a peripheral chip. An internal requester presents an address, write data and a direction. The block then steps through fixed phases, each with its own length, and drives the chip enable, address valid, output enable and write enable lines. The address goes either on dedicated address pins or, in multiplexed mode, also on the low data lanes during the address phase. For a read it waits for the device's ready line and hands back the captured data as a one-cycle response.

A small write-only configuration port sets the bus width (16 or 32 bits), the multiplexed mode, the early-ready mode, the polarity of each control line and every phase length. A stored timing value N always gives a phase of N+1 clock cycles. The block does no address decoding. The full 28-bit address, a 256 MB window, is passed straight to the pins.

Top module: `ext_bus_master`

## Requirements
- R1: While reset is high and after it, with no request pending: req_ready is 1, rsp_valid is 0, bus_dq_oe is 0 and the chip enable, address valid, output enable and write enable pins all sit at their inactive level (high, for the reset polarity settings).
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. After that, chip enable stays inactive for exactly setup+1 cycles and then goes active.
- R3: The address phase follows the setup phase. It lasts adv+1 cycles in normal mode and mux+1 cycles in multiplexed mode. Address valid is active during the first adv+1 cycles of that phase, cut short at the end of the phase. In multiplexed mode bus_dq_oe is 1 for every address-valid cycle and bus_dq_out carries the address, zero-extended and masked to the bus width. In normal mode a read leaves bus_dq_oe at 0 during the address phase.
- R4: For a write, write enable is active for exactly we+1 cycles. During those cycles bus_dq_oe is 1 and bus_dq_out carries the write data masked to the bus width. A wait phase of exactly wait+1 cycles follows, in which the ready input is ignored. Write enable and output enable are never active together.
- R5: For a read, output enable goes active for oe+1 cycles and stays active through the wait phase, which also lasts at least wait+1 cycles. Ready is looked at only from wait-phase cycle index wait onward, counting from 0. With early ready off, read data is captured in the first cycle from that index on in which ready is seen active. Output enable is never active while bus_dq_oe is 1.
- R6: With early ready on, capture happens one cycle after ready is first seen (index wait or later), and output enable stays active for that extra cycle.
- R7: After the last write-enable or output-enable cycle, chip enable stays active with no strobe. For a read this lasts hold+1 cycles. For a write it lasts the wait+1 wait cycles plus hold+1 cycles. The block then goes idle. The transfer's total busy length is the sum of its phases.
- R8: Config register 0 holds the mode bits, all reset to 0: bit 0 selects a 32-bit bus, bit 1 selects multiplexed mode, bit 2 selects early ready, bit 3 makes ready active-high, bit 4 makes address valid active-high, bit 5 makes both output enable and write enable active-high, bit 6 makes chip enable active-high. A cleared polarity bit means the line is active-low.
- R9: With the 16-bit bus, rsp_rdata[31:16] is zero and bus_dq_out[31:16] is zero. With the 32-bit bus all 32 bits pass through.
- R10: req_ready is 0 from the cycle after acceptance until the block is idle again. A read produces exactly one rsp_valid pulse, in the cycle after capture. A write produces none.
- R11: Config register 1 holds setup in bits [3:0] (reset 4), adv in [7:4] (reset 1), mux in [11:8] (reset 1), we in [15:12] (reset 1) and hold in [19:16] (reset 1). Register 2 holds oe in [7:0] (reset 1) and wait in [15:8] (reset 3). A register is written when cfg_we is 1, selected by cfg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 2 | Config register select (0 mode, 1 short timings, 2 long timings) |
| cfg_wdata | input | 20 | Config write data |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Transfer address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| bus_ce | output | 1 | Chip enable pin, polarity per config |
| bus_adv | output | 1 | Address valid pin, polarity per config |
| bus_oe | output | 1 | Output enable pin, polarity per config |
| bus_we | output | 1 | Write enable pin, polarity per config |
| bus_addr | output | 28 | Address pins |
| bus_dq_out | output | 32 | Data/address lanes driven out |
| bus_dq_oe | output | 1 | Output enable for the data lanes |
| bus_dq_in | input | 32 | Data lanes read back |
| bus_rdy | input | 1 | Device ready, polarity per config |

## Verification
The checker relies on configuration being written only while the block is idle. It also relies on a read's ready line eventually going active. It converts each pin to an active/inactive level using the current polarity bits, so a polarity change in the middle of a transfer is outside what it covers. The stimulus writes all three config registers between transfers, always while idle. A device model raises ready at a chosen wait-phase index and keeps it high until the block goes idle. It drives correct data only in the cycle the requirements name for capture, and inverted data otherwise.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  localparam int SHORT_W = 4;
  localparam int LONG_W  = 8;
  localparam int CFG_W   = 5 * SHORT_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_STROBE, ST_WAIT, ST_CAPT, ST_HOLD
  } phase_e;

  // bit 0 is wide, bit 6 is cs_hi
  typedef struct packed {
    logic cs_hi;
    logic strobe_hi;
    logic adv_hi;
    logic rdy_hi;
    logic rdy_early;
    logic muxed;
    logic wide;
  } mode_t;

  typedef struct packed {
    logic [LONG_W-1:0]  wait_w;
    logic [LONG_W-1:0]  oe_w;
    logic [SHORT_W-1:0] hold_w;
    logic [SHORT_W-1:0] we_w;
    logic [SHORT_W-1:0] mux_w;
    logic [SHORT_W-1:0] adv_w;
    logic [SHORT_W-1:0] ce_w;
  } timing_t;
endpackage

// File: rtl/ebm_cfg_regs.sv
module ebm_cfg_regs
  import ebm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output mode_t            mode,
  output timing_t          tim
);
  localparam int MODE_BITS = $bits(mode_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= '0;
      tim.ce_w   <= SHORT_W'(4);
      tim.adv_w  <= SHORT_W'(1);
      tim.mux_w  <= SHORT_W'(1);
      tim.we_w   <= SHORT_W'(1);
      tim.hold_w <= SHORT_W'(1);
      tim.oe_w   <= LONG_W'(1);
      tim.wait_w <= LONG_W'(3);
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: mode <= mode_t'(cfg_wdata[MODE_BITS-1:0]);
        2'd1: begin
          tim.ce_w   <= cfg_wdata[0*SHORT_W +: SHORT_W];
          tim.adv_w  <= cfg_wdata[1*SHORT_W +: SHORT_W];
          tim.mux_w  <= cfg_wdata[2*SHORT_W +: SHORT_W];
          tim.we_w   <= cfg_wdata[3*SHORT_W +: SHORT_W];
          tim.hold_w <= cfg_wdata[4*SHORT_W +: SHORT_W];
        end
        2'd2: begin
          tim.oe_w   <= cfg_wdata[0 +: LONG_W];
          tim.wait_w <= cfg_wdata[LONG_W +: LONG_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ebm_seq.sv
module ebm_seq
  import ebm_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              muxed,
  input  logic              rdy_early,
  input  timing_t           tim,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              rdy_act,
  input  logic [DATA_W-1:0] dq_in,
  output phase_e            ph_d,
  output logic [LONG_W-1:0] cnt_d,
  output logic              wr_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [DATA_W-1:0] wdat_d,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  phase_e            ph_q;
  logic [LONG_W-1:0] cnt_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic              capture;
  logic [LONG_W-1:0] addr_end;
  logic [LONG_W-1:0] strobe_end;

  assign addr_end   = muxed ? LONG_W'(tim.mux_w) : LONG_W'(tim.adv_w);
  assign strobe_end = wr_q ? LONG_W'(tim.we_w) : tim.oe_w;
  assign req_ready  = (ph_q == ST_IDLE);

  always_comb begin
    ph_d    = ph_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    capture = 1'b0;
    case (ph_q)
      ST_IDLE: if (req_valid) begin
        ph_d   = ST_SETUP;
        wr_d   = req_write;
        addr_d = req_addr;
        wdat_d = req_wdata;
      end
      ST_SETUP:  if (cnt_q == LONG_W'(tim.ce_w)) ph_d = ST_ADDR;
      ST_ADDR:   if (cnt_q == addr_end) ph_d = ST_STROBE;
      ST_STROBE: if (cnt_q == strobe_end) ph_d = ST_WAIT;
      ST_WAIT: if (cnt_q >= tim.wait_w) begin
        if (wr_q) begin
          ph_d = ST_HOLD;
        end else if (rdy_act) begin
          if (rdy_early) begin
            ph_d = ST_CAPT;
          end else begin
            ph_d    = ST_HOLD;
            capture = 1'b1;
          end
        end
      end
      ST_CAPT: begin
        ph_d    = ST_HOLD;
        capture = 1'b1;
      end
      ST_HOLD: if (cnt_q == LONG_W'(tim.hold_w)) ph_d = ST_IDLE;
      default: ph_d = ST_IDLE;
    endcase
    if (ph_d != ph_q)     cnt_d = '0;
    else if (cnt_q == '1) cnt_d = cnt_q;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= ST_IDLE;
      cnt_q     <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdat_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      ph_q      <= ph_d;
      cnt_q     <= cnt_d;
      wr_q      <= wr_d;
      addr_q    <= addr_d;
      wdat_q    <= wdat_d;
      rsp_valid <= capture;
      if (capture)
        rsp_rdata <= wide ? dq_in : DATA_W'(dq_in[NARROW_W-1:0]);
    end
  end
endmodule

// File: rtl/ebm_pads.sv
module ebm_pads
  import ebm_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wide,
  input  logic               muxed,
  input  logic               cs_hi,
  input  logic               adv_hi,
  input  logic               strobe_hi,
  input  logic [SHORT_W-1:0] adv_w,
  input  phase_e             ph_d,
  input  logic [LONG_W-1:0]  cnt_d,
  input  logic               wr_d,
  input  logic [ADDR_W-1:0]  addr_d,
  input  logic [DATA_W-1:0]  wdat_d,
  output logic               bus_ce,
  output logic               bus_adv,
  output logic               bus_oe,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_dq_out,
  output logic               bus_dq_oe
);
  logic ce_a, adv_a, oe_a, we_a, lane_a, dqoe_a;
  logic [DATA_W-1:0] dq_a;
  logic ce_q, adv_q, oe_q, we_q;

  always_comb begin
    ce_a   = (ph_d != ST_IDLE) && (ph_d != ST_SETUP);
    adv_a  = (ph_d == ST_ADDR) && (cnt_d <= LONG_W'(adv_w));
    oe_a   = !wr_d && ((ph_d == ST_STROBE) || (ph_d == ST_WAIT) || (ph_d == ST_CAPT));
    we_a   = wr_d && (ph_d == ST_STROBE);
    lane_a = (ph_d == ST_ADDR) && muxed;
    dqoe_a = lane_a || (wr_d && ((ph_d == ST_STROBE) || (ph_d == ST_WAIT)));
    dq_a   = lane_a ? DATA_W'(addr_d) : wdat_d;
    if (!wide) dq_a[DATA_W-1:NARROW_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q       <= 1'b0;
      adv_q      <= 1'b0;
      oe_q       <= 1'b0;
      we_q       <= 1'b0;
      bus_addr   <= '0;
      bus_dq_out <= '0;
      bus_dq_oe  <= 1'b0;
    end else begin
      ce_q       <= ce_a;
      adv_q      <= adv_a;
      oe_q       <= oe_a;
      we_q       <= we_a;
      bus_addr   <= addr_d;
      bus_dq_out <= dq_a;
      bus_dq_oe  <= dqoe_a;
    end
  end

  // polarity applied after the flop so a config change takes effect at once
  assign bus_ce  = ce_q  ^ ~cs_hi;
  assign bus_adv = adv_q ^ ~adv_hi;
  assign bus_oe  = oe_q  ^ ~strobe_hi;
  assign bus_we  = we_q  ^ ~strobe_hi;
endmodule

// File: rtl/ext_bus_master.sv
module ext_bus_master
  import ebm_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_ce,
  output logic              bus_adv,
  output logic              bus_oe,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dq_out,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_in,
  input  logic              bus_rdy
);
  mode_t             mode_q;
  timing_t           tim_q;
  logic              rdy_act;
  phase_e            ph_d;
  logic [LONG_W-1:0] cnt_d;
  logic              wr_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdat_d;

  assign rdy_act = bus_rdy ~^ mode_q.rdy_hi;

  ebm_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mode(mode_q), .tim(tim_q)
  );

  ebm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_seq (
    .clk(clk), .rst(rst), .wide(mode_q.wide), .muxed(mode_q.muxed),
    .rdy_early(mode_q.rdy_early), .tim(tim_q),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rdy_act(rdy_act), .dq_in(bus_dq_in),
    .ph_d(ph_d), .cnt_d(cnt_d), .wr_d(wr_d), .addr_d(addr_d), .wdat_d(wdat_d),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  ebm_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_pads (
    .clk(clk), .rst(rst), .wide(mode_q.wide), .muxed(mode_q.muxed),
    .cs_hi(mode_q.cs_hi), .adv_hi(mode_q.adv_hi), .strobe_hi(mode_q.strobe_hi),
    .adv_w(tim_q.adv_w), .ph_d(ph_d), .cnt_d(cnt_d), .wr_d(wr_d),
    .addr_d(addr_d), .wdat_d(wdat_d),
    .bus_ce(bus_ce), .bus_adv(bus_adv), .bus_oe(bus_oe), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe)
  );
endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_ce,
  input logic              bus_adv,
  input logic              bus_oe,
  input logic              bus_we,
  input logic              bus_dq_oe,
  input logic              wide,
  input logic              cs_hi,
  input logic              adv_hi,
  input logic              strobe_hi
);
  logic ce_on, adv_on, oe_on, we_on;
  assign ce_on  = bus_ce  ~^ cs_hi;
  assign adv_on = bus_adv ~^ adv_hi;
  assign oe_on  = bus_oe  ~^ strobe_hi;
  assign we_on  = bus_we  ~^ strobe_hi;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(ce_on || adv_on || oe_on || we_on));
  p_setup_ce_off_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !ce_on);
  p_adv_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    adv_on |-> !(oe_on || we_on));
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(oe_on && we_on));
  p_write_drives_r4: assert property (@(posedge clk) disable iff (rst)
    we_on |-> bus_dq_oe);
  p_read_released_r5: assert property (@(posedge clk) disable iff (rst)
    oe_on |-> !bus_dq_oe);
  p_strobe_in_ce_r7: assert property (@(posedge clk) disable iff (rst)
    (oe_on || we_on || adv_on) |-> ce_on);
  p_narrow_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !wide) |-> (rsp_rdata[DATA_W-1:NARROW_W] == '0));
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_single_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind ext_bus_master ebm_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .bus_ce(bus_ce), .bus_adv(bus_adv), .bus_oe(bus_oe), .bus_we(bus_we),
  .bus_dq_oe(bus_dq_oe), .wide(mode_q.wide), .cs_hi(mode_q.cs_hi),
  .adv_hi(mode_q.adv_hi), .strobe_hi(mode_q.strobe_hi)
);

// File: tb/ext_bus_master_bench.sv
module ext_bus_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 28;
  localparam int DW = 32;
  localparam int TXN_LIMIT = 3000;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [6:0]  mode;
    logic [19:0] t1;
    logic [15:0] t2;
    logic        wr;
    logic [27:0] addr;
    logic [31:0] wdata;
    logic [31:0] dev;
    logic [7:0]  rdy_at;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{7'h00, 20'h11114, 16'h0301, 1'b0, 28'h0000ABC, 32'h00000000, 32'hDEADBEEF, 8'd0},
    '{7'h00, 20'h11114, 16'h0301, 1'b1, 28'h0123456, 32'h12345678, 32'h00000000, 8'd0},
    '{7'h07, 20'h23520, 16'h0104, 1'b0, 28'h8765432, 32'h00000000, 32'hCAFEF00D, 8'd6},
    '{7'h7B, 20'h00162, 16'h0000, 1'b1, 28'h0F0F0F0, 32'hA5A55A5A, 32'h00000000, 8'd0},
    '{7'h78, 20'h32901, 16'h00FF, 1'b0, 28'h1234567, 32'h00000000, 32'h13579BDF, 8'd2},
    '{7'h15, 20'hFF0FF, 16'h0A02, 1'b0, 28'hABCDEF0, 32'h00000000, 32'h0F0FF0F0, 8'd0},
    '{7'h26, 20'h57203, 16'h1409, 1'b1, 28'hFFF1234, 32'hFFFF8001, 32'h00000000, 8'd0},
    '{7'h49, 20'h11111, 16'h0000, 1'b0, 28'h0000001, 32'h00000000, 32'h80000001, 8'd4}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [19:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          bus_ce, bus_adv, bus_oe, bus_we, bus_dq_oe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dq_out;
  logic [DW-1:0] bus_dq_in = '0;
  logic          bus_rdy = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_master u_ext_bus_master (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_ce(bus_ce), .bus_adv(bus_adv), .bus_oe(bus_oe), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe),
    .bus_dq_in(bus_dq_in), .bus_rdy(bus_rdy)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [19:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_txn(input vec_t v, input bit do_cfg);
    logic wide, muxed, early, rdy_hi, adv_hi, str_hi, cs_hi;
    int ce_w, adv_w, mux_w, we_w, hold_w, oe_w, wait_w, k_cap;
    int a_len, adv_exp, str_exp, tail_exp, total_exp;
    int total, setup, adv_n, str_n, oe_n, tail, rsp_n, lane_bad, wd_bad, addr_bad;
    bit ce_seen, str_seen, ce_on, adv_on, oe_on, we_on, rdy_a, good;
    logic [31:0] mask, got;
    string ttag, rtag;

    if (do_cfg) begin
      cfg_write(2'd0, {13'b0, v.mode});
      cfg_write(2'd1, v.t1);
      cfg_write(2'd2, {4'b0, v.t2});
    end
    wide = v.mode[0]; muxed = v.mode[1]; early = v.mode[2]; rdy_hi = v.mode[3];
    adv_hi = v.mode[4]; str_hi = v.mode[5]; cs_hi = v.mode[6];
    ce_w = int'(v.t1[3:0]); adv_w = int'(v.t1[7:4]); mux_w = int'(v.t1[11:8]);
    we_w = int'(v.t1[15:12]); hold_w = int'(v.t1[19:16]);
    oe_w = int'(v.t2[7:0]); wait_w = int'(v.t2[15:8]);
    k_cap = (int'(v.rdy_at) > wait_w) ? int'(v.rdy_at) : wait_w;
    a_len = muxed ? mux_w + 1 : adv_w + 1;
    adv_exp = (muxed && adv_w > mux_w) ? mux_w + 1 : adv_w + 1;
    str_exp = v.wr ? we_w + 1 : oe_w + 1 + k_cap + 1 + int'(early);
    tail_exp = v.wr ? wait_w + 1 + hold_w + 1 : hold_w + 1;
    total_exp = ce_w + 1 + a_len + str_exp + tail_exp;
    mask = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
    ttag = do_cfg ? "R7" : "R11";
    rtag = early ? "R6" : "R5";

    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    total = 0; setup = 0; adv_n = 0; str_n = 0; oe_n = 0; tail = 0; rsp_n = 0;
    lane_bad = 0; wd_bad = 0; addr_bad = 0; ce_seen = 0; str_seen = 0; got = '0;
    while (!req_ready && total <= TXN_LIMIT) begin
      total++;
      ce_on = bus_ce ~^ cs_hi; adv_on = bus_adv ~^ adv_hi;
      oe_on = bus_oe ~^ str_hi; we_on = bus_we ~^ str_hi;
      if (!ce_on && !ce_seen) setup++;
      if (ce_on) ce_seen = 1'b1;
      if (adv_on) begin
        adv_n++;
        if (muxed) begin
          if (bus_dq_oe !== 1'b1 || bus_dq_out !== (DW'(v.addr) & mask)) lane_bad++;
        end else if (!v.wr && bus_dq_oe !== 1'b0) lane_bad++;
      end
      if (we_on) begin
        str_n++;
        if (bus_dq_oe !== 1'b1 || bus_dq_out !== (v.wdata & mask)) wd_bad++;
      end
      if (oe_on) begin str_n++; oe_n++; end
      if (oe_on || we_on) str_seen = 1'b1;
      else if (str_seen && ce_on) tail++;
      if (ce_on && bus_addr !== v.addr) addr_bad++;
      if (rsp_valid) begin rsp_n++; got = rsp_rdata; end
      rdy_a = !v.wr && (oe_n >= oe_w + 2 + int'(v.rdy_at));
      good  = early ? (!v.wr && (oe_n >= oe_w + 3 + int'(v.rdy_at))) : rdy_a;
      bus_rdy = rdy_a ~^ rdy_hi;
      bus_dq_in = good ? v.dev : ~v.dev;
      @(negedge clk);
    end
    bus_rdy = ~rdy_hi;
    bus_dq_in = '0;

    chk(ttag, "busy cycles", 32'(total), 32'(total_exp));
    chk("R2", "setup cycles", 32'(setup), 32'(ce_w + 1));
    chk("R3", "address valid cycles", 32'(adv_n), 32'(adv_exp));
    chk("R3", "address lane errors", 32'(lane_bad), 32'd0);
    chk(v.wr ? "R4" : "R5", "strobe cycles", 32'(str_n), 32'(str_exp));
    chk("R7", "post-strobe cycles", 32'(tail), 32'(tail_exp));
    chk("R2", "address pin errors", 32'(addr_bad), 32'd0);
    chk("R8", "idle pin levels", {28'b0, bus_ce, bus_adv, bus_oe, bus_we},
        {28'b0, ~cs_hi, ~adv_hi, ~str_hi, ~str_hi});
    if (v.wr) begin
      chk("R4", "write data errors", 32'(wd_bad), 32'd0);
      chk("R10", "write responses", 32'(rsp_n), 32'd0);
    end else begin
      chk("R10", "read responses", 32'(rsp_n), 32'd1);
      chk(rtag, "read data", got, v.dev & mask);
      chk("R9", "read upper half", {16'b0, got[31:16]},
          wide ? {16'b0, v.dev[31:16]} : 32'd0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle levels while in reset
    chk("R1", "ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R1", "pins in reset", {27'b0, bus_ce, bus_adv, bus_oe, bus_we, bus_dq_oe},
        32'b11110);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1", "response after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1", "pins after reset", {27'b0, bus_ce, bus_adv, bus_oe, bus_we, bus_dq_oe},
        32'b11110);

    // R11: reset timing values without any config write
    run_txn(VECS[0], 1'b0);

    for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b1);

    // R5: ready well before the wait count must not shorten the wait
    run_txn('{7'h00, 20'h11110, 16'h0800, 1'b0, 28'h0000010, 32'h0, 32'h00C0FFEE, 8'd0}, 1'b1);
    // R6: early ready with ready arriving late in the wait phase
    run_txn('{7'h05, 20'h10000, 16'h0000, 1'b0, 28'h0000020, 32'h0, 32'h55AA33CC, 8'd9}, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule